// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

This block is a register window shared by a host processor and an embedded management controller. The host places up to 16 bytes of payload in a write buffer and then writes a command word. That single command write latches the command, sets a busy flag and pulses a doorbell toward the controller. The host then polls a status word until busy clears.

The controller reads the latched command and the write buffer through its own register port. It fills a read buffer with any response, and then posts a completion word that carries an error flag and an error code. Posting the completion clears busy. If the accepted command had its completion-interrupt bit set, a one-cycle interrupt pulse goes back to the host, and that pulse needs no clearing.

Both ports are plain synchronous register interfaces. Read data is registered and appears one cycle after the read strobe.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset, a host read of status (offset 0x04) returns busy=0, error=0, id=0 and code=0, with the initiator parameter in bits[15:8]. The doorbell and host interrupt outputs are low.
- R2: A host write to offset 0x00 while idle sets busy (status bit 0) and drives `c_doorbell` high for exactly the next cycle. A controller read of offset 0x00 then returns the written command word.
- R3: A host command write while busy is ignored. No doorbell is raised, and both the latched command and status stay unchanged.
- R4: Status bits[7:4] hold the command id (command bits[15:12]) of the last accepted command. Accepting a command clears the error bit and the error code.
- R5: Host writes to 0x80–0x8C fill the 4-word write buffer, which the controller reads at the same offsets. Host reads of write-only offsets (0x00, 0x80–0x8F) return zero.
- R6: Controller writes to 0x90–0x9C fill the read buffer. A host word read (`h_byte`=0) returns the whole word. A host byte read (`h_byte`=1) returns byte (addr[1:0]) of that word in bits[7:0], with byte 0 as the least significant byte.
- R7: A controller write to offset 0x04 while busy clears busy and loads error from bit 1 and the error code from bits[23:16] into status bits 1 and [23:16].
- R8: If command bit 8 was set, `h_irq` is high for exactly the one cycle after the completion write. If bit 8 was clear, `h_irq` stays low.
- R9: Host writes to read-only offsets (0x04, 0x90–0x9F) change neither status nor the read buffer.
- R10: A controller completion write while idle is ignored, and status stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | 8 | Host byte offset |
| h_byte | input | 1 | Host read width: 1 = byte, 0 = word |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after strobe |
| h_irq | output | 1 | Completion interrupt pulse to host |
| c_wr_en | input | 1 | Controller write strobe |
| c_rd_en | input | 1 | Controller read strobe |
| c_addr | input | 8 | Controller byte offset |
| c_wdata | input | 32 | Controller write data |
| c_rdata | output | 32 | Controller read data, one cycle after strobe |
| c_doorbell | output | 1 | Doorbell pulse to controller |

## Verification
Every result of this block sits exactly one register stage behind its cause. Read data, busy, status fields, the doorbell and the completion pulse all change at the clock edge that samples the strobe. The bench therefore drives each access for one cycle and samples one time unit after that edge. At that point it checks the pulse outputs for their single high cycle, and it checks them again one cycle later to confirm they have returned low.

// File: rtl/mbox_pkg.sv
// Shared offsets and the command word layout for the doorbell mailbox.
package mbox_pkg;
    localparam logic [7:0] CMD_OFS  = 8'h00;
    localparam logic [7:0] STAT_OFS = 8'h04;
    localparam logic [7:0] WBUF_OFS = 8'h80;
    localparam logic [7:0] RBUF_OFS = 8'h90;

    // Host command word; field positions are decoded by the controller.
    typedef struct packed {
        logic [7:0] hi_rsv;
        logic [7:0] nbytes;
        logic [3:0] tag;
        logic [2:0] lo_rsv;
        logic       want_irq;
        logic [7:0] opcode;
    } mbox_cmd_t;
endpackage

// File: rtl/mbox_buf.sv
// Word-addressed payload store with one write port and one combinational
// read port. Assumes indices are in range; the parent decodes the window.
module mbox_buf #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Hold one word; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[w] <= '0;
            else if (wr_en && wr_idx == IDX_W'(w))
                mem[w] <= wr_data;
        end
    end

    // Present the selected word.
    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/mbox_ctrl.sv
// Command latch and busy state. It accepts a command only while idle and
// pulses the doorbell. A completion post while busy ends the command, records
// the error, and pulses the host interrupt if the command asked for one.
module mbox_ctrl #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              done_wr,
    input  logic [WORD_W-1:0] done_data,
    output logic              busy,
    output logic              err,
    output logic [7:0]        err_code,
    output logic [WORD_W-1:0] cmd_word,
    output logic              doorbell,
    output logic              cpl_irq
);
    import mbox_pkg::*;

    mbox_cmd_t cmd_q;
    assign cmd_word = WORD_W'(cmd_q);

    // Sequence accept and complete; the pulses default low every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            err      <= 1'b0;
            err_code <= '0;
            cmd_q    <= '0;
            doorbell <= 1'b0;
            cpl_irq  <= 1'b0;
        end else begin
            doorbell <= 1'b0;
            cpl_irq  <= 1'b0;
            if (cmd_wr && !busy) begin
                busy     <= 1'b1;
                cmd_q    <= mbox_cmd_t'(cmd_data[31:0]);
                err      <= 1'b0;
                err_code <= '0;
                doorbell <= 1'b1;
            end else if (done_wr && busy) begin
                busy     <= 1'b0;
                err      <= done_data[1];
                err_code <= done_data[23:16];
                cpl_irq  <= cmd_q.want_irq;
            end
        end
    end
endmodule

// File: rtl/doorbell_mailbox.sv
// Top of the mailbox. It decodes both register ports, builds the status
// word, and registers the read data. It assumes single-cycle strobes and
// byte offsets within the window.
module doorbell_mailbox #(
    parameter int         BUF_BYTES = 16,
    parameter logic [7:0] INIT_ID   = 8'h5A,
    localparam int WORD_W    = 32,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr_en,
    input  logic              h_rd_en,
    input  logic [7:0]        h_addr,
    input  logic              h_byte,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic              c_wr_en,
    input  logic              c_rd_en,
    input  logic [7:0]        c_addr,
    input  logic [WORD_W-1:0] c_wdata,
    output logic [WORD_W-1:0] c_rdata,
    output logic              c_doorbell
);
    import mbox_pkg::*;

    logic              busy, err;
    logic [7:0]        err_code;
    logic [WORD_W-1:0] cmd_word, wbuf_word, rbuf_word, status;
    logic [7:0]        h_woff, h_roff, c_woff, c_roff;
    logic              h_in_wbuf, h_in_rbuf, c_in_wbuf, c_in_rbuf;
    logic [WORD_W-1:0] h_rd_next, c_rd_next;

    // Offsets relative to each buffer window.
    assign h_woff    = h_addr - WBUF_OFS;
    assign h_roff    = h_addr - RBUF_OFS;
    assign c_woff    = c_addr - WBUF_OFS;
    assign c_roff    = c_addr - RBUF_OFS;
    assign h_in_wbuf = 32'(h_woff) < BUF_BYTES;
    assign h_in_rbuf = 32'(h_roff) < BUF_BYTES;
    assign c_in_wbuf = 32'(c_woff) < BUF_BYTES;
    assign c_in_rbuf = 32'(c_roff) < BUF_BYTES;

    mbox_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (h_wr_en && h_addr == CMD_OFS),
        .cmd_data  (h_wdata),
        .done_wr   (c_wr_en && c_addr == STAT_OFS),
        .done_data (c_wdata),
        .busy      (busy),
        .err       (err),
        .err_code  (err_code),
        .cmd_word  (cmd_word),
        .doorbell  (c_doorbell),
        .cpl_irq   (h_irq)
    );

    // Host to controller payload.
    mbox_buf #(.WORDS(BUF_WORDS), .WORD_W(WORD_W)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (h_wr_en && h_in_wbuf),
        .wr_idx  (h_woff[IDX_W+1:2]),
        .wr_data (h_wdata),
        .rd_idx  (c_woff[IDX_W+1:2]),
        .rd_word (wbuf_word)
    );

    // Controller to host response.
    mbox_buf #(.WORDS(BUF_WORDS), .WORD_W(WORD_W)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (c_wr_en && c_in_rbuf),
        .wr_idx  (c_roff[IDX_W+1:2]),
        .wr_data (c_wdata),
        .rd_idx  (h_roff[IDX_W+1:2]),
        .rd_word (rbuf_word)
    );

    // Status word as the host sees it.
    assign status = {8'h00, err_code, INIT_ID, cmd_word[15:12], 2'b00, err, busy};

    // Host read decode: status, the read buffer by word or byte, else zero.
    always_comb begin
        h_rd_next = '0;
        if (h_addr == STAT_OFS)
            h_rd_next = status;
        else if (h_in_rbuf)
            h_rd_next = h_byte ? WORD_W'(rbuf_word[{h_addr[1:0], 3'b000} +: 8])
                               : rbuf_word;
    end

    // Controller read decode: latched command or write buffer, else zero.
    always_comb begin
        c_rd_next = '0;
        if (c_addr == CMD_OFS)
            c_rd_next = cmd_word;
        else if (c_in_wbuf)
            c_rd_next = wbuf_word;
    end

    // Register both read ports; zero when not reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata <= '0;
            c_rdata <= '0;
        end else begin
            h_rdata <= h_rd_en ? h_rd_next : '0;
            c_rdata <= c_rd_en ? c_rd_next : '0;
        end
    end
endmodule

// File: rtl/mbox_checker.sv
// Protocol properties of the mailbox, bound to the top module.
module mbox_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       h_wr_en,
    input logic [7:0] h_addr,
    input logic       c_wr_en,
    input logic [7:0] c_addr,
    input logic       busy,
    input logic       c_doorbell,
    input logic       h_irq
);
    import mbox_pkg::*;

    logic host_cmd, ctl_done;
    assign host_cmd = h_wr_en && h_addr == CMD_OFS;
    assign ctl_done = c_wr_en && c_addr == STAT_OFS;

    a_r2_accept_rings: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd && !busy) |=> (busy && c_doorbell));

    a_r3_busy_no_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd && busy) |=> !c_doorbell);

    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && busy) |=> !busy);

    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        h_irq |=> !h_irq);

    a_r8_irq_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        h_irq |-> $fell(busy));

    a_r10_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && !busy && !host_cmd) |=> !busy);
endmodule

bind doorbell_mailbox mbox_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_wr_en    (h_wr_en),
    .h_addr     (h_addr),
    .c_wr_en    (c_wr_en),
    .c_addr     (c_addr),
    .busy       (busy),
    .c_doorbell (c_doorbell),
    .h_irq      (h_irq)
);

// File: tb/doorbell_mailbox_test.sv
module doorbell_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr_en = 1'b0, h_rd_en = 1'b0, h_byte = 1'b0;
    logic [7:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_irq;
    logic        c_wr_en = 1'b0, c_rd_en = 1'b0;
    logic [7:0]  c_addr = '0;
    logic [31:0] c_wdata = '0;
    logic [31:0] c_rdata;
    logic        c_doorbell;

    int total = 0;
    int bad   = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    doorbell_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr), .h_byte(h_byte),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .c_wr_en(c_wr_en), .c_rd_en(c_rd_en), .c_addr(c_addr),
        .c_wdata(c_wdata), .c_rdata(c_rdata), .c_doorbell(c_doorbell)
    );

    // Step ops: 0 host write, 1 host read check, 2 ctrl write, 3 ctrl read check.
    // Fields: {req[3:0], op[1:0], byte, addr[7:0], data/expect[31:0]}.
    localparam int NV = 17;
    localparam logic [46:0] VEC [NV] = '{
        {4'd1,  2'd1, 1'b0, 8'h04, 32'h00005A00},  // R1 idle status
        {4'd5,  2'd0, 1'b0, 8'h80, 32'h11223344},  // R5
        {4'd5,  2'd0, 1'b0, 8'h8C, 32'hAABBCCDD},  // R5
        {4'd5,  2'd3, 1'b0, 8'h80, 32'h11223344},  // R5
        {4'd5,  2'd3, 1'b0, 8'h8C, 32'hAABBCCDD},  // R5
        {4'd5,  2'd1, 1'b0, 8'h80, 32'h00000000},  // R5 write-only reads zero
        {4'd2,  2'd0, 1'b0, 8'h00, 32'h000431FF},  // R2 command, id 3, irq
        {4'd2,  2'd3, 1'b0, 8'h00, 32'h000431FF},  // R2
        {4'd4,  2'd1, 1'b0, 8'h04, 32'h00005A31},  // R4 busy, id 3
        {4'd6,  2'd2, 1'b0, 8'h90, 32'h87654321},  // R6
        {4'd6,  2'd1, 1'b1, 8'h90, 32'h00000021},  // R6 byte 0
        {4'd6,  2'd1, 1'b1, 8'h93, 32'h00000087},  // R6 byte 3
        {4'd6,  2'd1, 1'b0, 8'h90, 32'h87654321},  // R6 word
        {4'd9,  2'd0, 1'b0, 8'h90, 32'h00000000},  // R9 write to read-only
        {4'd9,  2'd1, 1'b0, 8'h90, 32'h87654321},  // R9
        {4'd7,  2'd2, 1'b0, 8'h04, 32'h00420002},  // R7 complete with error
        {4'd7,  2'd1, 1'b0, 8'h04, 32'h00425A32}   // R7
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic h_write(input logic [7:0] a, input logic [31:0] d);
        h_wr_en = 1'b1; h_addr = a; h_wdata = d;
        @(posedge clk); #1;
        h_wr_en = 1'b0;
    endtask

    task automatic h_read(input logic [7:0] a, input logic b, output logic [31:0] d);
        h_rd_en = 1'b1; h_addr = a; h_byte = b;
        @(posedge clk); #1;
        h_rd_en = 1'b0; h_byte = 1'b0;
        d = h_rdata;
    endtask

    task automatic c_write(input logic [7:0] a, input logic [31:0] d);
        c_wr_en = 1'b1; c_addr = a; c_wdata = d;
        @(posedge clk); #1;
        c_wr_en = 1'b0;
    endtask

    task automatic c_read(input logic [7:0] a, output logic [31:0] d);
        c_rd_en = 1'b1; c_addr = a;
        @(posedge clk); #1;
        c_rd_en = 1'b0;
        d = c_rdata;
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: outputs quiet after reset
        check(1, {31'b0, c_doorbell}, 32'd0);
        check(1, {31'b0, h_irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic        bt;
            logic [7:0]  ad;
            logic [31:0] dt;
            {rq, op, bt, ad, dt} = VEC[i];
            case (op)
                2'd0: h_write(ad, dt);
                2'd1: begin h_read(ad, bt, v); check(int'(rq), v, dt); end
                2'd2: c_write(ad, dt);
                default: begin c_read(ad, v); check(int'(rq), v, dt); end
            endcase
        end

        // R2: doorbell pulse for one cycle on accept (id 2, no irq)
        h_write(8'h00, 32'h00002005);
        check(2, {31'b0, c_doorbell}, 32'd1);
        idle_cycle();
        check(2, {31'b0, c_doorbell}, 32'd0);
        h_read(8'h04, 1'b0, v);
        check(4, v, 32'h00005A21);  // R4: new id, error cleared

        // R3: command while busy is ignored
        h_write(8'h00, 32'h000071AA);
        check(3, {31'b0, c_doorbell}, 32'd0);
        c_read(8'h00, v);
        check(3, v, 32'h00002005);
        h_read(8'h04, 1'b0, v);
        check(3, v, 32'h00005A21);

        // R8: completion without the irq bit gives no pulse
        c_write(8'h04, 32'h00000000);
        check(8, {31'b0, h_irq}, 32'd0);
        h_read(8'h04, 1'b0, v);
        check(7, v, 32'h00005A20);

        // R10: completion while idle is ignored
        c_write(8'h04, 32'h00770002);
        h_read(8'h04, 1'b0, v);
        check(10, v, 32'h00005A20);

        // R9: host write to status does nothing
        h_write(8'h04, 32'hFFFFFFFF);
        h_read(8'h04, 1'b0, v);
        check(9, v, 32'h00005A20);

        // R5: host read of the command offset returns zero
        h_read(8'h00, 1'b0, v);
        check(5, v, 32'h00000000);

        // R8: irq bit set gives exactly one pulse at completion
        h_write(8'h00, 32'h00001100);
        check(8, {31'b0, h_irq}, 32'd0);
        c_write(8'h04, 32'h00000000);
        check(8, {31'b0, h_irq}, 32'd1);
        idle_cycle();
        check(8, {31'b0, h_irq}, 32'd0);
        h_read(8'h04, 1'b0, v);
        check(4, v, 32'h00005A10);

        // R1: reset returns status to idle
        rst_n = 1'b0;
        idle_cycle();
        rst_n = 1'b1;
        h_read(8'h04, 1'b0, v);
        check(1, v, 32'h00005A00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule